// File: doc/BRIEF.md
# Pseudo-Random Memory Fill and Verify Engine

This block is a simple bus master for testing a memory region. After a start pulse it writes a run of 32-bit words from a base byte address upward, one word per transfer. It then reads the same words back in the same order. For each word read it rebuilds the expected value from the word's index and compares it with the data returned. The result is a count of the words that did not match.

The data for each index comes from one of two sources. The first is a linear congruential formula. The second is the index itself, which gives data that is easy to recognise on a logic analyser. Only one transfer is outstanding at any time. A request stays asserted with steady address, direction and data until the memory acknowledges it.

A second start while a test is running is ignored. An optional debug capture records the index of the first word that failed and the data that was read there.

Top module: `lcg_mem_tester`

## Requirements
- R1: Out of reset, `mem_req`, `busy`, `done`, `fail_seen` are 0 and `err_count` is 0.
- R2: The word count, base address and mode are captured on the accepted start edge. Later changes on those inputs do not affect the running test.
- R3: In the write phase the engine issues exactly N writes (`mem_we`=1). Word i is written to byte address base + 4*i, with i going from 0 to N-1 in increasing order.
- R4: With `rand_mode`=1 the data for word i is (1664525*i + 1013904223) mod 2^32.
- R5: With `rand_mode`=0 the data for word i is i, zero-extended to 32 bits.
- R6: While `mem_req` is high and `mem_ack` is low, the request, address, direction and write data hold steady. The next transfer starts only after the cycle in which `mem_ack` is sampled high.
- R7: After the last write is acknowledged, the engine issues N reads (`mem_we`=0) at the same addresses and in the same order. No write follows a read within one test.
- R8: Each acknowledged read whose `mem_rdata` differs from the expected word adds one to `err_count`. Every word is read even after a mismatch, and the count is cleared on an accepted start.
- R9: `err_count` saturates at 2^ERR_W-1 and does not wrap.
- R10: `done` rises in the cycle after the last read acknowledge. It stays high with `busy` low and `err_count` steady until the next start. A count of zero at `done` means the region passed.
- R11: `fail_seen`, `fail_index` and `fail_data` record the index of the first mismatch and the data read there. They are not updated by later mismatches. If no mismatch occurs, `fail_seen` stays 0.
- R12: A start with N=0 goes straight to `done` in the next cycle, with `err_count`=0 and no transfer.
- R13: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when not busy |
| n_words | input | CNT_W | Number of words to test |
| base_addr | input | ADDR_W | Byte address of word 0 |
| rand_mode | input | 1 | 1: congruential data, 0: index data |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address of the transfer |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, result valid |
| err_count | output | ERR_W | Saturating mismatch count |
| fail_seen | output | 1 | At least one mismatch recorded |
| fail_index | output | CNT_W | Index of first mismatch |
| fail_data | output | 32 | Data read at first mismatch |

## Verification
A wrong word index or a stale latched base shows up at the first acknowledged transfer after the fault, as a wrong address or wrong write data. The memory-model scoreboard catches it in that same cycle. A phase sequencer that skips or repeats a step shows up as a request the scoreboard did not expect, or as a missing `done` before the timeout. A miscounting tally only shows up at `done`, so each test corrupts a known set of words and compares the final count and the captured first failure against the bench's own count.

// File: rtl/lcg_mem_pkg.sv
package lcg_mem_pkg;

    localparam int          WORD_W  = 32;
    localparam logic [31:0] LCG_MUL = 32'd1664525;
    localparam logic [31:0] LCG_INC = 32'd1013904223;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic              seen;
        logic [WORD_W-1:0] data;
    } fail_rec_t;

    function automatic logic [WORD_W-1:0] pattern_word(input logic [WORD_W-1:0] idx,
                                                       input logic              rnd);
        logic [WORD_W-1:0] prod;
        prod = idx * LCG_MUL;
        return rnd ? (prod + LCG_INC) : idx;
    endfunction

endpackage

// File: rtl/lcg_data_gen.sv
module lcg_data_gen
    import lcg_mem_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]  idx,
    input  logic              rnd,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] idx_ext;

    generate
        if (CNT_W < WORD_W) begin : g_pad
            assign idx_ext = {{(WORD_W-CNT_W){1'b0}}, idx};
        end else begin : g_cut
            assign idx_ext = idx[WORD_W-1:0];
        end
    endgenerate

    assign word = pattern_word(idx_ext, rnd);

endmodule

// File: rtl/lcg_seq_ctrl.sv
module lcg_seq_ctrl
    import lcg_mem_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  n_words,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              rand_mode,
    input  logic              ack,
    output phase_e            phase,
    output logic [CNT_W-1:0]  idx,
    output logic [ADDR_W-1:0] base_q,
    output logic              rnd_q,
    output logic              clear
);
    logic [CNT_W-1:0] count_q;
    logic             accept;
    logic             last;

    assign accept = start && (phase == PH_IDLE || phase == PH_DONE);
    assign last   = (idx == count_q - 1'b1);
    assign clear  = accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            count_q <= '0;
            base_q  <= '0;
            rnd_q   <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE, PH_DONE: begin
                    if (accept) begin
                        count_q <= n_words;
                        base_q  <= base_addr;
                        rnd_q   <= rand_mode;
                        idx     <= '0;
                        phase   <= (n_words == '0) ? PH_DONE : PH_WRITE;
                    end
                end
                PH_WRITE: begin
                    if (ack) begin
                        if (last) begin
                            idx   <= '0;
                            phase <= PH_READ;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_READ: begin
                    if (ack) begin
                        if (last) phase <= PH_DONE;
                        else      idx   <= idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7
    read_order_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ) |=> (phase == PH_READ || phase == PH_DONE));

    // R13
    busy_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE || phase == PH_READ) |=>
            ($stable(base_q) && $stable(count_q) && $stable(rnd_q)));

    // R12
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && n_words == '0) |=> (phase == PH_DONE));

endmodule

// File: rtl/lcg_err_tally.sv
module lcg_err_tally
    import lcg_mem_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ERR_W  = 16,
    parameter bit DBG_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              strobe,
    input  logic              mismatch,
    input  logic [CNT_W-1:0]  idx,
    input  logic [WORD_W-1:0] rdata,
    output logic [ERR_W-1:0]  err_count,
    output logic              fail_seen,
    output logic [CNT_W-1:0]  fail_index,
    output logic [WORD_W-1:0] fail_data
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear)
            err_count <= '0;
        else if (strobe && mismatch && err_count != ERR_MAX)
            err_count <= err_count + 1'b1;
    end

    generate
        if (DBG_EN) begin : g_dbg
            fail_rec_t        rec;
            logic [CNT_W-1:0] rec_idx;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    rec     <= '0;
                    rec_idx <= '0;
                end else if (strobe && mismatch && !rec.seen) begin
                    rec.seen <= 1'b1;
                    rec.data <= rdata;
                    rec_idx  <= idx;
                end
            end

            assign fail_seen  = rec.seen;
            assign fail_data  = rec.data;
            assign fail_index = rec_idx;

            // R11
            first_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (fail_seen && !clear) |=>
                    (fail_seen && $stable(fail_index) && $stable(fail_data)));
        end else begin : g_nodbg
            assign fail_seen  = 1'b0;
            assign fail_data  = '0;
            assign fail_index = '0;
        end
    endgenerate

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_count == ERR_MAX && !clear) |=> (err_count == ERR_MAX));

    // R8
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

endmodule

// File: rtl/lcg_mem_tester.sv
module lcg_mem_tester
    import lcg_mem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int ERR_W  = 16,
    parameter bit DBG_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  n_words,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              rand_mode,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ERR_W-1:0]  err_count,
    output logic              fail_seen,
    output logic [CNT_W-1:0]  fail_index,
    output logic [31:0]       fail_data
);
    phase_e            phase;
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] base_q;
    logic              rnd_q;
    logic              clear;
    logic [WORD_W-1:0] pat;
    logic              strobe;
    logic              mismatch;

    lcg_seq_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .n_words   (n_words),
        .base_addr (base_addr),
        .rand_mode (rand_mode),
        .ack       (mem_ack),
        .phase     (phase),
        .idx       (idx),
        .base_q    (base_q),
        .rnd_q     (rnd_q),
        .clear     (clear)
    );

    lcg_data_gen #(.CNT_W(CNT_W)) i_gen (
        .idx  (idx),
        .rnd  (rnd_q),
        .word (pat)
    );

    assign mem_req   = (phase == PH_WRITE) || (phase == PH_READ);
    assign mem_we    = (phase == PH_WRITE);
    assign mem_addr  = base_q + ADDR_W'({idx, 2'b00});
    assign mem_wdata = pat;
    assign busy      = mem_req;
    assign done      = (phase == PH_DONE);
    assign strobe    = (phase == PH_READ) && mem_ack;
    assign mismatch  = (mem_rdata != pat);

    lcg_err_tally #(.CNT_W(CNT_W), .ERR_W(ERR_W), .DBG_EN(DBG_EN)) i_tally (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .strobe     (strobe),
        .mismatch   (mismatch),
        .idx        (idx),
        .rdata      (mem_rdata),
        .err_count  (err_count),
        .fail_seen  (fail_seen),
        .fail_index (fail_index),
        .fail_data  (fail_data)
    );

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R3
    addr_stride_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_we) |=>
            (!mem_we || mem_addr == $past(mem_addr) + ADDR_W'(4)));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && !busy && $stable(err_count)));

endmodule

// File: tb/test_lcg_mem_tester.sv
module test_lcg_mem_tester;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int ERR_W  = 4;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  n_words = '0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              rand_mode = 1'b0;
    logic              mem_req, mem_we, busy, done, fail_seen;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, fail_data;
    logic              mem_ack = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic [ERR_W-1:0]  err_count;
    logic [CNT_W-1:0]  fail_index;

    int checks = 0;
    int failures = 0;
    exp_t exp_q[$];
    logic [31:0] mem_m [0:63];
    bit corrupt [0:63];
    int lat_cnt = 0;
    int lat_seed = 0;
    string tag = "R3";

    always #5 clk = ~clk;

    lcg_mem_tester #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .DBG_EN(1'b1)) i_lcg_mem_tester (
        .clk(clk), .rst(rst), .start(start), .n_words(n_words), .base_addr(base_addr),
        .rand_mode(rand_mode), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .err_count(err_count), .fail_seen(fail_seen), .fail_index(fail_index),
        .fail_data(fail_data)
    );

    function automatic logic [31:0] exp_word(input int i, input bit rnd);
        logic [31:0] v;
        v = 32'(i);
        return rnd ? (v * 32'd1664525 + 32'd1013904223) : v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Scoreboard driver: push the expected transfer sequence for one test
    task automatic push_job(input int n, input logic [31:0] base, input bit rnd);
        for (int i = 0; i < n; i++) exp_q.push_back('{1'b1, base + 32'(4*i), exp_word(i, rnd)});
        for (int i = 0; i < n; i++) exp_q.push_back('{1'b0, base + 32'(4*i), exp_word(i, rnd)});
    endtask

    task automatic go(input int n, input logic [31:0] base, input bit rnd);
        @(negedge clk);
        n_words = CNT_W'(n); base_addr = base; rand_mode = rnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done;
        for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    endtask

    // Memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected request", mem_addr, 32'h0);
                end else if (lat_cnt > 0) begin
                    chk(mem_addr == exp_q[0].addr && mem_we == exp_q[0].we, "R6 hold", mem_addr, exp_q[0].addr);
                    lat_cnt--;
                end else begin
                    chk(mem_we == exp_q[0].we, exp_q[0].we ? "R3 direction" : "R7 direction",
                        32'(mem_we), 32'(exp_q[0].we));
                    chk(mem_addr == exp_q[0].addr, exp_q[0].we ? "R3 address" : "R7 address",
                        mem_addr, exp_q[0].addr);
                    if (exp_q[0].we) begin
                        chk(mem_wdata == exp_q[0].data, tag, mem_wdata, exp_q[0].data);
                        mem_m[mem_addr[7:2]] = mem_wdata;
                    end else begin
                        mem_rdata = mem_m[mem_addr[7:2]] ^ (corrupt[mem_addr[7:2]] ? 32'h100 : 32'h0);
                    end
                    void'(exp_q.pop_front());
                    mem_ack = 1'b1;
                    lat_seed++;
                    lat_cnt = lat_seed % 3;
                end
            end
        end
    end

    task automatic end_job(input string req, input int exp_err);
        wait_done();
        chk(done == 1'b1, "R10 done", 32'(done), 32'd1);
        chk(busy == 1'b0, "R10 busy low", 32'(busy), 32'd0);
        chk(exp_q.size() == 0, "R8 all words read", 32'(exp_q.size()), 32'd0);
        chk(err_count == ERR_W'(exp_err), req, 32'(err_count), 32'(exp_err));
    endtask

    initial begin
        for (int k = 0; k < 64; k++) begin mem_m[k] = '0; corrupt[k] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(mem_req == 1'b0 && busy == 1'b0, "R1 idle request", 32'(mem_req), 32'd0);
        chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
        chk(err_count == '0 && fail_seen == 1'b0, "R1 count", 32'(err_count), 32'd0);

        // R4: random data, clean memory
        tag = "R4 random data";
        push_job(10, 32'h100, 1'b1);
        go(10, 32'h100, 1'b1);
        end_job("R8 clean count", 0);
        chk(fail_seen == 1'b0, "R11 no failure", 32'(fail_seen), 32'd0);
        repeat (4) @(negedge clk);
        chk(done == 1'b1 && err_count == '0, "R10 held", 32'(done), 32'd1);

        // R5: index data
        tag = "R5 index data";
        push_job(7, 32'h40, 1'b0);
        go(7, 32'h40, 1'b0);
        end_job("R8 index count", 0);

        // R2 and R13: inputs change and start pulses mid-run
        tag = "R2 latched data";
        push_job(6, 32'h80, 1'b1);
        go(6, 32'h80, 1'b1);
        n_words = 16'd3; base_addr = 32'h0; rand_mode = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        end_job("R13 ignored start count", 0);

        // R8 and R11: two corrupted words
        tag = "R4 random data";
        corrupt[2] = 1'b1; corrupt[5] = 1'b1;
        push_job(8, 32'h0, 1'b1);
        go(8, 32'h0, 1'b1);
        end_job("R8 two mismatches", 2);
        chk(fail_seen == 1'b1, "R11 seen", 32'(fail_seen), 32'd1);
        chk(fail_index == 16'd2, "R11 first index", 32'(fail_index), 32'd2);
        chk(fail_data == (exp_word(2, 1'b1) ^ 32'h100), "R11 first data", fail_data,
            exp_word(2, 1'b1) ^ 32'h100);

        // R12: zero length
        go(0, 32'h0, 1'b1);
        chk(done == 1'b1 && busy == 1'b0, "R12 done at once", 32'(done), 32'd1);
        chk(err_count == '0, "R12 cleared count", 32'(err_count), 32'd0);
        repeat (3) @(negedge clk);

        // R9: saturation
        tag = "R5 index data";
        for (int k = 0; k < 64; k++) corrupt[k] = 1'b1;
        push_job(20, 32'h0, 1'b0);
        go(20, 32'h0, 1'b0);
        end_job("R9 saturated count", 15);
        chk(fail_index == 16'd0, "R11 first of many", 32'(fail_index), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule